// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns a single pulse-width-modulated command into the two gate signals of a half-bridge: one for the switch on the supply side and one for the switch on the ground side. While the command is high the supply-side switch is on, and while it is low the ground-side switch is on. Whenever the command changes level, both gates are first held off for a programmed number of clock ticks. The incoming switch turns on only after that gap, so the two switches never conduct together.

The gap length is an 8-bit tick count. It is latched at the moment a gap opens, so each gap runs to its full length. A command pulse that is no longer than the gap never reaches a gate. A glitch inside a gap restarts the gap. The period counter and compare logic that produce the command sit upstream of this block. Fault shutdown lies outside it.

Top module: `comp_pwm_deadtime`

## Requirements
- R1: When the block is enabled and the command has been stable long enough, `hi_out` follows `pwm_in` and `lo_out` is its inverse (command 1 gives hi=1, lo=0; command 0 gives hi=0, lo=1).
- R2: `hi_out` and `lo_out` are never both 1 in any cycle.
- R3: A restart is any rising clock edge where one of these holds: the sampled command differs from its value at the previous edge, `en` is low, or `en` was low at the previous edge. At a restart edge E with latched gap D > 0, both outputs are 0 from edge E through edge E+D-1. The active output turns on at edge E+D if no further restart occurs.
- R4: A restart inside a gap starts the count again from zero. A command level that lasts D or fewer clock edges therefore never drives either output.
- R5: With a gap of 0, a command change switches both outputs at the same edge, with no both-off cycle.
- R6: `dt_cfg` is an unsigned 8-bit tick count, latched only at a restart edge. A change at any other time has no effect on the outputs until the next restart.
- R7: While `en` is low, both outputs are 0 from the next rising edge on. Raising `en` is treated as a restart, so the first gap after enabling runs in full.
- R8: While `rst_n` is low, both outputs are 0 at once and stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; low forces both gates off |
| pwm_in | input | 1 | PWM command, synchronous to clk |
| dt_cfg | input | 8 | Dead-time length in clock ticks |
| hi_out | output | 1 | Supply-side switch gate, active high |
| lo_out | output | 1 | Ground-side switch gate, active high |

## Verification
The assertions assume that `pwm_in`, `en` and `dt_cfg` are synchronous to `clk` and settle before each rising edge. They also assume the command is a plain level with no ordering against `dt_cfg` updates. The bench changes every input only at falling edges and samples the outputs at the following falling edge. It moves `dt_cfg` both while an output is on and at a transition, so that both the latched value and the ignored value are exercised. The absorbed-pulse case uses command levels of exactly two edges against a three-tick gap.

// File: rtl/comp_pwm_deadtime.sv
module comp_pwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            pwm_in,
  input  logic [DT_W-1:0] dt_cfg,
  output logic            hi_out,
  output logic            lo_out
);

  localparam logic [DT_W-1:0] ONE = {{(DT_W-1){1'b0}}, 1'b1};

  logic            in_q;
  logic            en_q;
  logic [DT_W-1:0] dt_q;
  logic [DT_W-1:0] cnt_q;

  logic            restart;
  logic [DT_W-1:0] dt_nxt;
  logic [DT_W-1:0] cnt_nxt;
  logic            ready;

  assign restart = (pwm_in != in_q) | ~en | ~en_q;
  assign dt_nxt  = restart ? dt_cfg : dt_q;
  assign cnt_nxt = restart ? '0 : ((cnt_q >= dt_q) ? cnt_q : cnt_q + ONE);
  assign ready   = en & (cnt_nxt >= dt_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      en_q   <= 1'b0;
      dt_q   <= '0;
      cnt_q  <= '0;
      hi_out <= 1'b0;
      lo_out <= 1'b0;
    end else begin
      in_q   <= pwm_in;
      en_q   <= en;
      dt_q   <= dt_nxt;
      cnt_q  <= cnt_nxt;
      hi_out <= ready & pwm_in;
      lo_out <= ready & ~pwm_in;
    end
  end

endmodule

// File: rtl/comp_pwm_deadtime_chk.sv
module comp_pwm_deadtime_chk #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            pwm_in,
  input logic            hi_out,
  input logic            lo_out,
  input logic [DT_W-1:0] dt_q
);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_out && lo_out));

  assert_hi_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hi_out |-> $past(pwm_in));

  assert_lo_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lo_out |-> !$past(pwm_in));

  assert_off_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_out || lo_out) |-> $past(en));

  assert_gap_before_turn_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_out) && dt_q != '0) |-> !$past(lo_out));

  assert_gap_before_low_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_out) && dt_q != '0) |-> !$past(hi_out));

  assert_dt_latch_while_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dt_q) && dt_q != '0) |-> (!hi_out && !lo_out));

endmodule

bind comp_pwm_deadtime comp_pwm_deadtime_chk #(.DT_W(DT_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .pwm_in (pwm_in),
  .hi_out (hi_out),
  .lo_out (lo_out),
  .dt_q   (dt_q)
);

// File: tb/comp_pwm_deadtime_tb_top.sv
`timescale 1ns/1ps
module comp_pwm_deadtime_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       pwm_in = 1'b1;
  logic [7:0] dt_cfg = 8'd2;
  logic       hi_out;
  logic       lo_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  comp_pwm_deadtime #(.DT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_in(pwm_in),
    .dt_cfg(dt_cfg), .hi_out(hi_out), .lo_out(lo_out)
  );

  // fields: en, pwm, dt, exp_hi, exp_lo, requirement number
  localparam int NV = 30;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd2, 1'b0, 1'b0, 4'd7},  // enable acts as restart
    {1'b1, 1'b0, 8'd2, 1'b0, 1'b0, 4'd3},
    {1'b1, 1'b0, 8'd2, 1'b0, 1'b1, 4'd3},
    {1'b1, 1'b0, 8'd2, 1'b0, 1'b1, 4'd1},
    {1'b1, 1'b1, 8'd2, 1'b0, 1'b0, 4'd3},
    {1'b1, 1'b1, 8'd2, 1'b0, 1'b0, 4'd3},
    {1'b1, 1'b1, 8'd2, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b1, 8'd2, 1'b1, 1'b0, 4'd1},
    {1'b1, 1'b0, 8'd2, 1'b0, 1'b0, 4'd4},  // one-edge low pulse
    {1'b1, 1'b1, 8'd2, 1'b0, 1'b0, 4'd4},
    {1'b1, 1'b1, 8'd2, 1'b0, 1'b0, 4'd4},
    {1'b1, 1'b1, 8'd2, 1'b1, 1'b0, 4'd4},
    {1'b1, 1'b1, 8'd5, 1'b1, 1'b0, 4'd6},  // dt change while on
    {1'b1, 1'b0, 8'd5, 1'b0, 1'b0, 4'd6},
    {1'b1, 1'b0, 8'd5, 1'b0, 1'b0, 4'd6},
    {1'b1, 1'b0, 8'd5, 1'b0, 1'b0, 4'd6},
    {1'b1, 1'b0, 8'd5, 1'b0, 1'b0, 4'd6},
    {1'b1, 1'b0, 8'd5, 1'b0, 1'b0, 4'd6},
    {1'b1, 1'b0, 8'd5, 1'b0, 1'b1, 4'd6},
    {1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 4'd6},
    {1'b1, 1'b1, 8'd0, 1'b1, 1'b0, 4'd5},  // zero gap
    {1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 4'd5},
    {1'b1, 1'b1, 8'd0, 1'b1, 1'b0, 4'd5},
    {1'b0, 1'b1, 8'd0, 1'b0, 1'b0, 4'd7},
    {1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 4'd7},
    {1'b1, 1'b0, 8'd1, 1'b0, 1'b0, 4'd7},
    {1'b1, 1'b0, 8'd1, 1'b0, 1'b1, 4'd7},
    {1'b1, 1'b1, 8'd1, 1'b0, 1'b0, 4'd3},
    {1'b1, 1'b1, 8'd1, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b1, 8'd3, 1'b1, 1'b0, 4'd6}
  };

  function automatic string req_name(int k);
    case (k)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic eh, input logic el);
    total++;
    if (hi_out !== eh || lo_out !== el || (hi_out === 1'b1 && lo_out === 1'b1)) begin
      bad++;
      $display("FAIL %s: hi/lo actual=%b%b expected=%b%b at %0t", req, hi_out, lo_out, eh, el, $time);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R8", 1'b0, 1'b0);
    en = 1'b0;
    pwm_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      en     = VEC[i][15];
      pwm_in = VEC[i][14];
      dt_cfg = VEC[i][13:6];
      @(negedge clk);
      check(req_name(int'(VEC[i][3:0])), VEC[i][5], VEC[i][4]);
    end

    rst_n = 1'b0;
    #1;
    check("R8", 1'b0, 1'b0);
    @(negedge clk);
    check("R2", 1'b0, 1'b0);
    rst_n = 1'b1;
    en = 1'b1;
    dt_cfg = 8'd3;

    for (int k = 0; k < 14; k++) begin
      pwm_in = (k < 12) ? logic'((k >> 1) & 1) : 1'b1;
      @(negedge clk);
      if (k == 13) check("R4", 1'b1, 1'b0);
      else         check("R4", 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule